// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the time of day and the calendar date in packed BCD registers and advances them once per second. It keeps seconds, minutes, hours, day of week, date, month with a century bit, and a two-digit year. The one-second tick comes from a binary divider that counts enable pulses from a 32.768 kHz reference. The hours register carries its own format bit, so the count follows either a 24-hour sequence or a 12-hour sequence with a PM bit. The date rolls over at the end of each month according to the month length and a leap-year rule.

A host writes any field through a parallel write port. Selector value 7 writes a control byte that halts the oscillator and clears the oscillator-stop flag. An oscillator-valid input and the halt bit together decide whether the divider runs. The flag records every stop of the oscillator. The divider's top bit comes out as a 1 Hz square wave.

Top module: `bcd_rtc_core`

## Requirements
- R1: After a synchronous reset the time is sec 00, min 00, hour 0x00 (24-hour midnight), day of week 01, date 01, month 0x01 (century 0) and year 00. The halt bit is 0, the stop flag is 1 and the square wave is 0.
- R2: While running (halt 0 and osc_ok 1), each ref_tick pulse advances a DIV_BITS-bit divider. The pulse that wraps the divider from all-ones to zero is the one-second tick, and the square-wave output equals the divider's top bit.
- R3: Seconds and minutes count 00 to 59 in BCD. A wrap of the seconds advances the minutes, and a wrap of the minutes advances the hours.
- R4: With hour bit 6 = 0 (24-hour), hours count 0x00 to 0x23, bit 5 being the tens digit of 20 to 23. The wrap from 0x23 to 0x00 advances the date.
- R5: With hour bit 6 = 1 (12-hour), bit 5 = 1 means PM and bits 4:0 hold 01 to 12 in BCD. The sequence runs 12 AM, 1 AM … 11 AM, 12 PM, 1 PM … 11 PM, 12 AM. Only the 11 PM to 12 AM step advances the date.
- R6: The date wraps to 01 after 30 in April, June, September and November and after 31 in the other long months. February ends on 29 when the BCD year is divisible by 4 and on 28 otherwise. A wrap after December gives month 01 and advances the year.
- R7: When the year wraps from 0x99 to 0x00, month bit 7 (century) toggles.
- R8: The day of week counts 1 to 7, wrapping 7 to 1, and it advances on the same tick as the date.
- R9: With wr_en high, wr_sel selects the field: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year. The data is stored masked (sec, min and hour 0x7F; day of week 0x07; date 0x3F; month 0x9F; year 0xFF) at the next clock edge. A write to any of these fields in the cycle of a tick cancels that tick's increment of every field.
- R10: A seconds write clears the divider in the same edge, so the square wave rises exactly 2^(DIV_BITS-1) ref_tick pulses after that write.
- R11: wr_sel = 7 writes the control byte, and its bit 7 is the halt bit. While halt is 1 or osc_ok is 0, the divider and all time fields hold their values (host writes excepted).
- R12: The stop flag is set on the edge after running falls from 1 to 0. A control write with bit 6 = 0 clears it, a control write with bit 6 = 1 leaves it unchanged, and a set in the same edge wins over a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| osc_ok | input | 1 | Reference oscillator is valid |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format and PM bits |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD, with century in bit 7 |
| year_o | output | 8 | Year, BCD |
| halt_o | output | 1 | Oscillator halt bit |
| stop_flag_o | output | 1 | Oscillator-stop flag |
| sqw_o | output | 1 | 1 Hz square wave (divider top bit) |

## Verification
A host write and the one-second tick can land on the same clock edge. The bench provokes this by watching its own divider model and issuing a minutes write, and later a seconds write, in exactly the cycle whose ref_tick wraps the divider. The reference model is updated every clock, and it expects the written value, a cancelled increment of the seconds and the divider cleared or wrapped to zero. Rollover cases (month ends, leap February, year 99, 11 PM) are each set up just before the tick so that carry chains and a concurrent write both get exercised.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_time_t;

    typedef enum logic [2:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DOW   = 3'd3,
        SEL_DATE  = 3'd4,
        SEL_MONTH = 3'd5,
        SEL_YEAR  = 3'd6,
        SEL_CTRL  = 3'd7
    } wr_sel_e;

    localparam logic [7:0] MASK_SEC   = 8'h7F;
    localparam logic [7:0] MASK_MIN   = 8'h7F;
    localparam logic [7:0] MASK_HOUR  = 8'h7F;
    localparam logic [7:0] MASK_DOW   = 8'h07;
    localparam logic [7:0] MASK_DATE  = 8'h3F;
    localparam logic [7:0] MASK_MONTH = 8'h9F;

    localparam rtc_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         dow: 8'h01, date: 8'h01, month: 8'h01,
                                         year: 8'h00};

    // Add one to the low BCD digit, carrying into the upper nibble.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'h1};
        return r;
    endfunction

    // BCD year divisible by four: even tens with ones 0/4/8, odd tens with ones 2/6.
    function automatic logic is_leap(input logic tens_odd, input logic [1:0] ones_lo);
        return (ones_lo == 2'b00 && !tens_odd) || (ones_lo == 2'b10 && tens_odd);
    endfunction

    function automatic logic [5:0] last_date(input logic [4:0] mon, input logic leap);
        logic [5:0] r;
        case (mon)
            5'h02:                      r = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

    // Returns {day_carry, next_hour} for either format.
    function automatic logic [8:0] hour_next(input logic [7:0] h);
        logic [7:0] n;
        logic       c;
        n = bcd_inc(h);
        c = 1'b0;
        if (h[6]) begin
            if (h[4:0] == 5'h11) begin
                n = {h[7:6], ~h[5], 5'h12};
                c = h[5];
            end else if (h[4:0] == 5'h12) begin
                n = {h[7:5], 5'h01};
            end
        end else if (h[5:0] == 6'h23) begin
            n = {h[7:6], 6'h00};
            c = 1'b1;
        end
        return {c, n};
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic run,
    input  logic clr,
    output logic sec_tick,
    output logic sqw
);
    localparam logic [DIV_BITS-1:0] DIV_LAST = '1;

    logic [DIV_BITS-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (ref_tick && run)
            cnt <= cnt + 1'b1;
    end

    assign sec_tick = ref_tick && run && (cnt == DIV_LAST);
    assign sqw      = cnt[DIV_BITS-1];
endmodule

// File: rtl/rtc_osc_monitor.sv
module rtc_osc_monitor (
    input  logic clk,
    input  logic rst,
    input  logic osc_ok,
    input  logic ctrl_wr,
    input  logic halt_val,
    input  logic keep_flag,
    output logic halt_q,
    output logic running,
    output logic stop_flag
);
    logic run_q;

    assign running = !halt_q && osc_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q    <= 1'b0;
            run_q     <= 1'b0;
            stop_flag <= 1'b1;
        end else begin
            run_q <= running;
            if (ctrl_wr)
                halt_q <= halt_val;
            if (run_q && !running)
                stop_flag <= 1'b1;
            else if (ctrl_wr && !keep_flag)
                stop_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output rtc_time_t  cur
);
    rtc_time_t  nxt;
    logic [8:0] hr;
    logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;
    logic [5:0] end_date;

    always_comb begin
        nxt      = cur;
        hr       = hour_next(cur.hour);
        end_date = last_date(cur.month[4:0], is_leap(cur.year[4], cur.year[1:0]));
        c_min    = (cur.sec == 8'h59);
        c_hr     = c_min && (cur.min == 8'h59);
        c_day    = c_hr && hr[8];
        c_mon    = c_day && (cur.date[5:0] == end_date);
        c_yr     = c_mon && (cur.month[4:0] == 5'h12);
        c_cen    = c_yr && (cur.year == 8'h99);

        nxt.sec = c_min ? 8'h00 : bcd_inc(cur.sec);
        if (c_min)
            nxt.min = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);
        if (c_hr)
            nxt.hour = hr[7:0];
        if (c_day) begin
            nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'h01;
            nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
        end
        if (c_mon)
            nxt.month = c_yr ? {cur.month[7] ^ c_cen, 7'h01} : bcd_inc(cur.month);
        if (c_yr)
            nxt.year = c_cen ? 8'h00 : bcd_inc(cur.year);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= TIME_RESET;
        end else if (wr_en && wr_sel != SEL_CTRL) begin
            case (wr_sel)
                SEL_SEC:   cur.sec   <= wr_data & MASK_SEC;
                SEL_MIN:   cur.min   <= wr_data & MASK_MIN;
                SEL_HOUR:  cur.hour  <= wr_data & MASK_HOUR;
                SEL_DOW:   cur.dow   <= wr_data & MASK_DOW;
                SEL_DATE:  cur.date  <= wr_data & MASK_DATE;
                SEL_MONTH: cur.month <= wr_data & MASK_MONTH;
                default:   cur.year  <= wr_data;
            endcase
        end else if (sec_tick) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic       osc_ok,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       halt_o,
    output logic       stop_flag_o,
    output logic       sqw_o
);
    rtc_time_t tm;
    logic      running;
    logic      sec_tick;
    logic      ctrl_wr;
    logic      sec_wr;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign sec_wr  = wr_en && (wr_sel == SEL_SEC);

    rtc_osc_monitor u_osc (
        .clk       (clk),
        .rst       (rst),
        .osc_ok    (osc_ok),
        .ctrl_wr   (ctrl_wr),
        .halt_val  (wr_data[7]),
        .keep_flag (wr_data[6]),
        .halt_q    (halt_o),
        .running   (running),
        .stop_flag (stop_flag_o)
    );

    rtc_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .run      (running),
        .clr      (sec_wr),
        .sec_tick (sec_tick),
        .sqw      (sqw_o)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cur      (tm)
    );

    assign sec_o   = tm.sec;
    assign min_o   = tm.min;
    assign hour_o  = tm.hour;
    assign dow_o   = tm.dow;
    assign date_o  = tm.date;
    assign month_o = tm.month;
    assign year_o  = tm.year;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic       clk,
    input logic       rst,
    input logic       osc_ok,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic       halt_o,
    input logic       stop_flag_o
);
    // R1: reset puts seconds at zero and raises the stop flag
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sec_o == 8'h00 && stop_flag_o));

    // R9: a seconds write lands masked at the next edge
    a_r9_sec_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0) |=> (sec_o == ($past(wr_data) & 8'h7F)));

    // R11: nothing moves while stopped and not written
    a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
        ((halt_o || !osc_ok) && !wr_en) |=>
            ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o)));

    // R12: a fall of the running state raises the flag
    a_r12_flag_on_stop: assert property (@(posedge clk) disable iff (rst)
        ($past(!halt_o && osc_ok) && (halt_o || !osc_ok)) |=> stop_flag_o);

    // R7: year wrap from 99 toggles the century bit
    a_r7_century: assert property (@(posedge clk) disable iff (rst)
        ($past(year_o) == 8'h99 && year_o == 8'h00 && !$past(wr_en)) |->
            (month_o[7] != $past(month_o[7])));
endmodule

bind bcd_rtc_core rtc_checker u_chk (.*);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
    localparam int DIVB = 4;
    localparam int DIVN = 1 << DIVB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b1;
    logic       osc_ok = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       halt_o, stop_flag_o, sqw_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int tick_every = 1;
    int tick_cnt = 0;
    bit cmp_on = 0;

    // behavioural reference state
    logic [7:0] ms, mm, mh, mdow, mdt, mmo, myr;
    bit  mhalt, mflag, mrunq;
    int  mdiv;

    bcd_rtc_core #(.DIV_BITS(DIVB)) u_bcd_rtc_core (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .osc_ok(osc_ok),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .halt_o(halt_o), .stop_flag_o(stop_flag_o), .sqw_o(sqw_o)
    );

    always #10 clk = ~clk;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        logic [7:0] r;
        r[7:4] = 4'((v / 10) % 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    task automatic advance();
        int s, m, h12, h24, d, mo, y, dim;
        bit pm;
        s = b2i(ms) + 1;
        if (s < 60) begin ms = i2b(s); return; end
        ms = 8'h00;
        m = b2i(mm) + 1;
        if (m < 60) begin mm = i2b(m); return; end
        mm = 8'h00;
        if (mh[6]) begin
            h12 = b2i(mh & 8'h1F); pm = mh[5];
            h24 = (h12 % 12) + (pm ? 12 : 0);
        end else begin
            h24 = b2i(mh & 8'h3F);
        end
        h24 = (h24 + 1) % 24;
        if (mh[6]) begin
            h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
            mh = 8'h40 | (h24 >= 12 ? 8'h20 : 8'h00) | i2b(h12);
        end else begin
            mh = i2b(h24);
        end
        if (h24 != 0) return;
        mdow = (mdow == 8'd7) ? 8'd1 : mdow + 8'd1;
        mo = b2i(mmo & 8'h1F);
        y  = b2i(myr);
        case (mo)
            2: dim = (y % 4 == 0) ? 29 : 28;
            4, 6, 9, 11: dim = 30;
            default: dim = 31;
        endcase
        d = b2i(mdt) + 1;
        if (d <= dim) begin mdt = i2b(d); return; end
        mdt = 8'h01;
        mo = mo + 1;
        if (mo <= 12) begin mmo = (mmo & 8'h80) | i2b(mo); return; end
        mmo = (mmo & 8'h80) | 8'h01;
        y = y + 1;
        if (y < 100) myr = i2b(y);
        else begin myr = 8'h00; mmo = mmo ^ 8'h80; end
    endtask

    always @(posedge clk) begin
        bit run, tk;
        if (rst) begin
            ms = 8'h00; mm = 8'h00; mh = 8'h00; mdow = 8'h01; mdt = 8'h01;
            mmo = 8'h01; myr = 8'h00; mhalt = 0; mflag = 1; mrunq = 0; mdiv = 0;
        end else begin
            run = !mhalt && osc_ok;
            tk  = ref_tick && run && (mdiv == DIVN - 1);
            if (wr_en && wr_sel == 3'd0) mdiv = 0;
            else if (ref_tick && run) mdiv = (mdiv + 1) % DIVN;
            if (mrunq && !run) mflag = 1;
            else if (wr_en && wr_sel == 3'd7 && !wr_data[6]) mflag = 0;
            mrunq = run;
            if (wr_en && wr_sel == 3'd7) mhalt = wr_data[7];
            if (wr_en && wr_sel != 3'd7) begin
                case (wr_sel)
                    3'd0: ms   = wr_data & 8'h7F;
                    3'd1: mm   = wr_data & 8'h7F;
                    3'd2: mh   = wr_data & 8'h7F;
                    3'd3: mdow = wr_data & 8'h07;
                    3'd4: mdt  = wr_data & 8'h3F;
                    3'd5: mmo  = wr_data & 8'h9F;
                    default: myr = wr_data;
                endcase
            end else if (tk) begin
                advance();
            end
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", what, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            chk("R3 seconds", sec_o, ms);
            chk("R3 minutes", min_o, mm);
            chk("R4,R5 hours", hour_o, mh);
            chk("R8 day of week", dow_o, mdow);
            chk("R6 date", date_o, mdt);
            chk("R6,R7 month", month_o, mmo);
            chk("R6 year", year_o, myr);
            chk("R11 halt", {7'd0, halt_o}, {7'd0, mhalt});
            chk("R12 stop flag", {7'd0, stop_flag_o}, {7'd0, mflag});
            chk("R2,R10 square wave", {7'd0, sqw_o}, {7'd0, 1'(mdiv >= DIVN / 2)});
        end
        if (cycles > 200000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // reference pulse generator
    always @(negedge clk) begin
        tick_cnt++;
        ref_tick <= (tick_cnt % tick_every) == 0;
    end

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_now(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] dw, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
        wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
    endtask

    initial begin
        logic [7:0] held;
        run_cycles(3);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;
        // R1 reset state
        chk("R1 reset sec", sec_o, 8'h00);
        chk("R1 reset hour", hour_o, 8'h00);
        chk("R1 reset dow", dow_o, 8'h01);
        chk("R1 reset month", month_o, 8'h01);
        chk("R1 reset flag", {7'd0, stop_flag_o}, 8'h01);
        chk("R1 reset sqw", {7'd0, sqw_o}, 8'h00);

        wr(3'd7, 8'h00);
        chk("R12 flag cleared", {7'd0, stop_flag_o}, 8'h00);
        run_cycles(40);

        // R10: square wave rises half a second after a seconds write
        wr(3'd0, 8'h10);
        run_cycles(DIVN / 2 - 1);
        chk("R10 sqw still low", {7'd0, sqw_o}, 8'h00);
        run_cycles(1);
        chk("R10 sqw rises", {7'd0, sqw_o}, 8'h01);

        // R6 non-leap February end, R8 dow wrap
        set_time(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
        run_cycles(40);
        chk("R6 Feb28 -> Mar01 date", date_o, 8'h01);
        chk("R6 Feb28 -> Mar01 month", month_o, 8'h03);
        chk("R8 dow 7 -> 1", dow_o, 8'h01);

        // R6 leap February
        set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h58);
        run_cycles(40);
        chk("R6 leap Feb29", date_o, 8'h29);

        // R6 thirty-day month
        set_time(8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h58);
        run_cycles(40);
        chk("R6 Apr30 -> May", month_o, 8'h05);

        // R7 year and century wrap
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h58);
        run_cycles(40);
        chk("R7 year wrap", year_o, 8'h00);
        chk("R7 century toggled", month_o, 8'h81);

        // R5 11 PM -> 12 AM advances date
        set_time(8'h10, 8'h05, 8'h14, 8'h02, 8'h71, 8'h59, 8'h58);
        run_cycles(40);
        chk("R5 11PM -> 12AM", hour_o, 8'h52);
        chk("R5 date advanced", date_o, 8'h15);

        // R5 11 AM -> 12 PM keeps date
        set_time(8'h10, 8'h05, 8'h14, 8'h02, 8'h51, 8'h59, 8'h58);
        run_cycles(40);
        chk("R5 11AM -> 12PM", hour_o, 8'h72);
        chk("R5 date kept", date_o, 8'h14);
        set_time(8'h10, 8'h05, 8'h14, 8'h02, 8'h72, 8'h59, 8'h59);
        run_cycles(20);
        chk("R5 12PM -> 1PM", hour_o, 8'h61);

        // R4 24-hour wrap
        set_time(8'h10, 8'h05, 8'h14, 8'h02, 8'h23, 8'h59, 8'h59);
        run_cycles(20);
        chk("R4 23 -> 00", hour_o, 8'h00);

        // R9 write on the tick cycle cancels the increment
        while (mdiv != DIVN - 1) @(negedge clk);
        held = sec_o;
        wr_now(3'd1, 8'h42);
        chk("R9 minute written on tick", min_o, 8'h42);
        chk("R9 seconds not advanced", sec_o, held);
        while (mdiv != DIVN - 1) @(negedge clk);
        wr_now(3'd0, 8'hB7);
        chk("R9 masked seconds on tick", sec_o, 8'h37);
        wr(3'd3, 8'hFD);
        chk("R9 dow mask", dow_o, 8'h05);

        // R2 irregular reference pulses
        tick_every = 3;
        run_cycles(120);
        tick_every = 1;

        // R11 halt, R12 flag set and write-one ignored
        wr(3'd7, 8'h80);
        run_cycles(1);
        chk("R12 flag set on halt", {7'd0, stop_flag_o}, 8'h01);
        held = sec_o;
        run_cycles(40);
        chk("R11 frozen while halted", sec_o, held);
        wr(3'd7, 8'h40);
        chk("R12 write 1 keeps flag", {7'd0, stop_flag_o}, 8'h01);
        wr(3'd7, 8'h00);
        chk("R12 flag cleared", {7'd0, stop_flag_o}, 8'h00);
        run_cycles(20);
        @(negedge clk);
        osc_ok = 1'b0;
        run_cycles(2);
        chk("R12 flag set on invalid clock", {7'd0, stop_flag_o}, 8'h01);
        held = sec_o;
        run_cycles(40);
        chk("R11 frozen without clock", sec_o, held);
        osc_ok = 1'b1;
        run_cycles(40);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule